// File: doc/BRIEF.md
# Crypto Engine Bus Strobe Adapter

This block sits between an asynchronous processor/DMA I/O bus and a cipher engine. The engine samples its bus on clock-aligned address and data strobes, so the adapter resynchronises the bus read and write strobes to the engine clock. It then issues one engine strobe per bus access, with guaranteed minimum and maximum widths. The processor first writes a register-select port, which produces an address strobe. After that, DMA transfers (hold-acknowledge plus DMA acknowledge) and processor accesses to the data port each produce only a data strobe. Data can therefore stream with no address phase.

Each engine access follows a fixed sequence of clock phases. The direction line is set first and left alone for a setup interval. The strobe then falls and stays low until both the minimum width has passed and the bus has released its strobe. A maximum-width counter ends the strobe early if the bus stretches its cycle too long. While the minimum width runs, the ready line to the DMA is held low. After the strobe rises, the engine bus enable stays on for a data hold interval. A separate reset request drives both strobes low together and releases them on one clock edge.

All timing limits are given as clock-cycle parameters (`SETUP_CYC`, `MIN_CYC`, `MAX_CYC`, `HOLD_CYC`). With the default values and a 20 MHz clock, these give 100 ns setup, a strobe of 200 ns to 950 ns, and 100 ns hold.

Top module: `crypto_strobe_adapter`

## Requirements
- R1: While `rst` is high and after it is released, `eng_as_n` and `eng_ds_n` are 1, `eng_rw` is 1, `dma_rdy` is 1 and `eng_bus_en` is 0.
- R2: A bus access whose `bus_addr` equals `ADDR_PORT` (default 8'h40), made while DMA is not acknowledged, pulses `eng_as_n` low and never `eng_ds_n`. It also sets the engine-select state.
- R3: A bus access to `DATA_PORT` (default 8'h41), or any access while both `dma_hlda` and `dma_dack` are high regardless of address, pulses `eng_ds_n` low and never `eng_as_n`.
- R4: Once started, an engine strobe stays low for at least `MIN_CYC` clock cycles, even when the bus strobe is shorter. A bus pulse shorter than the minimum gives a strobe of exactly `MIN_CYC` cycles.
- R5: An engine strobe stays low for at most `MAX_CYC` cycles. If the bus holds its strobe longer, the engine strobe rises at `MAX_CYC`, and no further engine strobe starts until the bus strobe is released.
- R6: `eng_rw` equals the inverse of `bus_dtr` at detection (1 = engine read, 0 = engine write). It holds that value for at least `SETUP_CYC` cycles before the strobe falls and does not change while the strobe is low.
- R7: `dma_rdy` goes low when an engine access is detected. It returns high only after the engine strobe has been low for `MIN_CYC` cycles.
- R8: `eng_bus_en` stays high for at least `HOLD_CYC` cycles after an engine strobe rises.
- R9: While `dma_hlda` is high and the engine-select state is set, `eng_bus_en` stays high. A bus access to any other port during that time does not clear it. A processor access to another port while `dma_hlda` is low clears the select state.
- R10: A bus access to an undecoded port, made while DMA is not acknowledged, produces no engine strobe and leaves `dma_rdy` high.
- R11: While the synchronised `eng_rst_req` is high, `eng_as_n` and `eng_ds_n` are both low and `dma_rdy` is high. Both strobes rise on the same clock edge after the request drops, and neither strobe is ever low alone because of the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd_n | input | 1 | Asynchronous bus read strobe, active low |
| bus_wr_n | input | 1 | Asynchronous bus write strobe, active low |
| bus_dtr | input | 1 | Bus transmit/receive: 1 = bus writes to the engine |
| bus_addr | input | ADDR_W | I/O port address of the bus cycle |
| dma_hlda | input | 1 | DMA hold acknowledge |
| dma_dack | input | 1 | DMA acknowledge for the engine channel |
| eng_rst_req | input | 1 | Asynchronous engine reset request |
| eng_as_n | output | 1 | Engine address strobe, active low |
| eng_ds_n | output | 1 | Engine data strobe, active low |
| eng_rw | output | 1 | Engine direction: 1 = read from engine |
| dma_rdy | output | 1 | Ready to the DMA/processor |
| eng_bus_en | output | 1 | Engine data bus enable |

## Verification
On every cycle, the bound checker checks the bounds on strobe width, direction setup and stability, ready being held through the minimum width, bus enable during the hold interval, and the rule that reset pairs the two strobes. These are counted with cycle counters, so they do not depend on how large the parameters are. Only the directed scenarios can show which strobe a given port address or DMA condition selects. They also show that a short pulse yields exactly the minimum width, that a long stretch is capped at the maximum with no second strobe, that undecoded accesses have no effect, and how the engine-select state survives or is cleared by foreign accesses.

// File: rtl/csa_pkg.sv
package csa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DRAIN,
        ST_RESET
    } phase_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ADDR,
        ACC_DATA
    } acc_t;

    // Bundle of asynchronous bus controls that cross into the engine clock
    typedef struct packed {
        logic strobe;
        logic dtr;
        logic hlda;
        logic dack;
        logic rst_req;
    } bus_ctl_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/csa_sync.sv
module csa_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/csa_port_decode.sv
module csa_port_decode
    import csa_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_PORT = 8'h40,
    parameter logic [ADDR_W-1:0] DATA_PORT = 8'h41
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hlda_s,
    input  logic              dack_s,
    output acc_t              kind
);
    always_comb begin
        if (hlda_s) begin
            // DMA owns the bus: only the engine channel acknowledge counts
            kind = dack_s ? ACC_DATA : ACC_NONE;
        end else if (addr == ADDR_PORT) begin
            kind = ACC_ADDR;
        end else if (addr == DATA_PORT) begin
            kind = ACC_DATA;
        end else begin
            kind = ACC_NONE;
        end
    end
endmodule

// File: rtl/csa_strobe_seq.sv
module csa_strobe_seq
    import csa_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int MIN_CYC   = 4,
    parameter int MAX_CYC   = 19,
    parameter int HOLD_CYC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_s,
    input  logic rst_req_s,
    input  logic hlda_s,
    input  logic dtr_s,
    input  acc_t kind,
    output logic as_n,
    output logic ds_n,
    output logic rw,
    output logic rdy,
    output logic busy,
    output logic sel
);
    localparam int CNT_TOP = max3(SETUP_CYC, MAX_CYC, HOLD_CYC);
    localparam int CNT_W   = $clog2(CNT_TOP + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] MIN_LAST   = CNT_W'(MIN_CYC - 1);
    localparam logic [CNT_W-1:0] MAX_LAST   = CNT_W'(MAX_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    acc_t             kind_q;
    logic             min_met;
    logic             end_strobe;

    assign min_met    = (cnt >= MIN_LAST);
    assign end_strobe = (min_met && !strobe_s) || (cnt == MAX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= ST_IDLE;
            cnt    <= '0;
            kind_q <= ACC_NONE;
            as_n   <= 1'b1;
            ds_n   <= 1'b1;
            rw     <= 1'b1;
            rdy    <= 1'b1;
            busy   <= 1'b0;
            sel    <= 1'b0;
        end else if (rst_req_s) begin
            // joint low strobes signal engine reset
            phase <= ST_RESET;
            cnt   <= '0;
            as_n  <= 1'b0;
            ds_n  <= 1'b0;
            rdy   <= 1'b1;
            busy  <= 1'b0;
            sel   <= 1'b0;
        end else begin
            unique case (phase)
                ST_RESET: begin
                    as_n  <= 1'b1;
                    ds_n  <= 1'b1;
                    phase <= ST_DRAIN;
                end
                ST_IDLE: begin
                    if (strobe_s) begin
                        if (kind == ACC_NONE) begin
                            if (!hlda_s) sel <= 1'b0;
                            phase <= ST_DRAIN;
                        end else begin
                            kind_q <= kind;
                            rw     <= ~dtr_s;
                            rdy    <= 1'b0;
                            busy   <= 1'b1;
                            cnt    <= '0;
                            if (kind == ACC_ADDR) sel <= 1'b1;
                            phase  <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        cnt   <= '0;
                        phase <= ST_STROBE;
                        if (kind_q == ACC_ADDR) as_n <= 1'b0;
                        else                    ds_n <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (min_met) rdy <= 1'b1;
                    if (end_strobe) begin
                        as_n  <= 1'b1;
                        ds_n  <= 1'b1;
                        cnt   <= '0;
                        phase <= ST_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        busy  <= 1'b0;
                        phase <= ST_DRAIN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (!strobe_s) phase <= ST_IDLE;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crypto_strobe_adapter.sv
module crypto_strobe_adapter
    import csa_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_PORT = 8'h40,
    parameter logic [ADDR_W-1:0] DATA_PORT = 8'h41,
    parameter int                SYNC_STG  = 2,
    parameter int                SETUP_CYC = 2,
    parameter int                MIN_CYC   = 4,
    parameter int                MAX_CYC   = 19,
    parameter int                HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              bus_dtr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              dma_hlda,
    input  logic              dma_dack,
    input  logic              eng_rst_req,
    output logic              eng_as_n,
    output logic              eng_ds_n,
    output logic              eng_rw,
    output logic              dma_rdy,
    output logic              eng_bus_en
);
    localparam int CTL_W = $bits(bus_ctl_t);

    bus_ctl_t         ctl_raw;
    bus_ctl_t         ctl_s;
    logic [CTL_W-1:0] ctl_q;
    acc_t             kind;
    logic             busy;
    logic             sel;
    logic             rst_req_sync;

    always_comb begin
        ctl_raw.strobe  = ~bus_rd_n | ~bus_wr_n;
        ctl_raw.dtr     = bus_dtr;
        ctl_raw.hlda    = dma_hlda;
        ctl_raw.dack    = dma_dack;
        ctl_raw.rst_req = eng_rst_req;
    end

    csa_sync #(.W(CTL_W), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_q)
    );

    assign ctl_s        = bus_ctl_t'(ctl_q);
    assign rst_req_sync = ctl_s.rst_req;

    csa_port_decode #(
        .ADDR_W   (ADDR_W),
        .ADDR_PORT(ADDR_PORT),
        .DATA_PORT(DATA_PORT)
    ) u_dec (
        .addr  (bus_addr),
        .hlda_s(ctl_s.hlda),
        .dack_s(ctl_s.dack),
        .kind  (kind)
    );

    csa_strobe_seq #(
        .SETUP_CYC(SETUP_CYC),
        .MIN_CYC  (MIN_CYC),
        .MAX_CYC  (MAX_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe_s (ctl_s.strobe),
        .rst_req_s(rst_req_sync),
        .hlda_s   (ctl_s.hlda),
        .dtr_s    (ctl_s.dtr),
        .kind     (kind),
        .as_n     (eng_as_n),
        .ds_n     (eng_ds_n),
        .rw       (eng_rw),
        .rdy      (dma_rdy),
        .busy     (busy),
        .sel      (sel)
    );

    // engine stays enabled for the whole DMA hold when it was selected
    assign eng_bus_en = busy | (ctl_s.hlda & sel);
endmodule

// File: rtl/crypto_strobe_adapter_chk.sv
module crypto_strobe_adapter_chk #(
    parameter int SETUP_CYC = 2,
    parameter int MIN_CYC   = 4,
    parameter int MAX_CYC   = 19
) (
    input logic clk,
    input logic rst,
    input logic eng_as_n,
    input logic eng_ds_n,
    input logic eng_rw,
    input logic dma_rdy,
    input logic eng_bus_en,
    input logic rst_req_sync
);
    localparam int LW = $clog2(MAX_CYC + 2);
    localparam int AW = $clog2(SETUP_CYC + 2);
    localparam logic [LW-1:0] LOW_CAP = LW'(MAX_CYC + 1);
    localparam logic [AW-1:0] AGE_CAP = AW'(SETUP_CYC);

    logic          solo;
    logic [LW-1:0] low_cnt;
    logic [AW-1:0] rw_age;
    logic          rw_q;

    assign solo = eng_as_n ^ eng_ds_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            rw_age  <= AGE_CAP;
            rw_q    <= 1'b1;
        end else begin
            if (!solo)                low_cnt <= '0;
            else if (low_cnt != LOW_CAP) low_cnt <= low_cnt + 1'b1;
            rw_q <= eng_rw;
            if (eng_rw != rw_q)         rw_age <= AW'(1);
            else if (rw_age != AGE_CAP) rw_age <= rw_age + 1'b1;
        end
    end

    // R4
    a_r4_min_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(solo) && eng_as_n && eng_ds_n) |-> (low_cnt >= LW'(MIN_CYC)));

    // R5
    a_r5_max_width: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LW'(MAX_CYC));

    // R6
    a_r6_setup: assert property (@(posedge clk) disable iff (rst)
        $rose(solo) |-> (rw_age >= AGE_CAP));

    // R6
    a_r6_rw_stable: assert property (@(posedge clk) disable iff (rst)
        (solo && $past(solo)) |-> $stable(eng_rw));

    // R7
    a_r7_rdy_held: assert property (@(posedge clk) disable iff (rst)
        (solo && (low_cnt < LW'(MIN_CYC))) |-> !dma_rdy);

    // R8
    a_r8_hold_en: assert property (@(posedge clk) disable iff (rst)
        ($fell(solo) && eng_as_n && eng_ds_n) |-> eng_bus_en);

    // R11
    a_r11_joint_reset: assert property (@(posedge clk) disable iff (rst)
        (!eng_as_n && !eng_ds_n) |-> ($past(rst_req_sync) && dma_rdy));
endmodule

bind crypto_strobe_adapter crypto_strobe_adapter_chk #(
    .SETUP_CYC(SETUP_CYC),
    .MIN_CYC  (MIN_CYC),
    .MAX_CYC  (MAX_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .eng_as_n    (eng_as_n),
    .eng_ds_n    (eng_ds_n),
    .eng_rw      (eng_rw),
    .dma_rdy     (dma_rdy),
    .eng_bus_en  (eng_bus_en),
    .rst_req_sync(rst_req_sync)
);

// File: tb/crypto_strobe_adapter_test.sv
`timescale 1ns/1ps
module crypto_strobe_adapter_test;
    localparam int CLK_PERIOD = 50;
    localparam int SETUP_CYC  = 2;
    localparam int MIN_CYC    = 4;
    localparam int MAX_CYC    = 19;
    localparam int HOLD_CYC   = 2;
    localparam logic [7:0] P_ADDR = 8'h40;
    localparam logic [7:0] P_DATA = 8'h41;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_dtr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic dma_hlda = 1'b0, dma_dack = 1'b0, eng_rst_req = 1'b0;
    logic eng_as_n, eng_ds_n, eng_rw, dma_rdy, eng_bus_en;

    int checks = 0, failures = 0;
    bit done = 0;

    // observation statistics
    int as_lo, ds_lo, falls, width, cur_run, rw_age, age_at_fall;
    int rw_flips, rdy_early, en_after, en_lo;
    bit rdy_seen_low, in_after, prev_low, rw_at_fall, prev_rw;

    always #(CLK_PERIOD/2) clk = ~clk;

    crypto_strobe_adapter uut (
        .clk(clk), .rst(rst), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_dtr(bus_dtr), .bus_addr(bus_addr), .dma_hlda(dma_hlda),
        .dma_dack(dma_dack), .eng_rst_req(eng_rst_req), .eng_as_n(eng_as_n),
        .eng_ds_n(eng_ds_n), .eng_rw(eng_rw), .dma_rdy(dma_rdy),
        .eng_bus_en(eng_bus_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        as_lo = 0; ds_lo = 0; falls = 0; width = 0; cur_run = 0;
        age_at_fall = -1; rw_flips = 0; rdy_early = 0; en_after = 0;
        en_lo = 0; rdy_seen_low = 0; in_after = 0;
    endtask

    task automatic observe();
        bit la, ld, lo;
        @(negedge clk);
        la = !eng_as_n && eng_ds_n;
        ld = eng_as_n && !eng_ds_n;
        lo = la || ld;
        if (la) as_lo++;
        if (ld) ds_lo++;
        if (eng_rw != prev_rw) begin
            rw_age = 0;
            if (lo && prev_low) rw_flips++;
        end
        if (lo && !prev_low) begin
            falls++; age_at_fall = rw_age; cur_run = 0; rw_at_fall = eng_rw;
        end
        if (lo) begin
            if (cur_run < MIN_CYC && dma_rdy) rdy_early++;
            cur_run++;
            if (cur_run > width) width = cur_run;
        end
        if (!lo && prev_low) begin in_after = 1; en_after = 0; end
        if (in_after) begin
            if (eng_bus_en) en_after++; else in_after = 0;
        end
        if (!dma_rdy) rdy_seen_low = 1;
        if (!eng_bus_en) en_lo++;
        rw_age++;
        prev_rw = eng_rw;
        prev_low = lo;
    endtask

    task automatic bus_cycle(input logic [7:0] a, input bit wr, input int stretch,
                             input bit wait_rdy);
        int guard;
        clear_stats();
        bus_addr = a;
        bus_dtr  = wr;
        if (wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
        if (wait_rdy) begin
            guard = 0;
            do begin observe(); guard++; end
            while (!(rdy_seen_low && dma_rdy) && guard < 80);
        end else begin
            observe();
        end
        for (int i = 0; i < stretch; i++) observe();
        bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        for (int i = 0; i < 30; i++) observe();
    endtask

    task automatic t_reset_state();
        observe();
        chk(eng_as_n && eng_ds_n, "R1", "strobes idle in reset", {eng_as_n, eng_ds_n}, 3);
        chk(dma_rdy && eng_rw && !eng_bus_en, "R1", "rdy/rw/en in reset",
            {dma_rdy, eng_rw, eng_bus_en}, 6);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) observe();
        chk(eng_as_n && eng_ds_n && dma_rdy && eng_rw && !eng_bus_en, "R1",
            "state after release", {eng_as_n, eng_ds_n, dma_rdy, eng_rw, eng_bus_en}, 5'b11110);
    endtask

    task automatic t_addr_write();
        bus_cycle(P_ADDR, 1'b1, 0, 1'b1);
        chk(as_lo > 0 && ds_lo == 0, "R2", "address port strobes as/ds", as_lo*100 + ds_lo, 1);
        chk(rw_at_fall == 1'b0, "R6", "rw for write", rw_at_fall, 0);
        chk(age_at_fall >= SETUP_CYC, "R6", "rw setup cycles", age_at_fall, SETUP_CYC);
        chk(rw_flips == 0, "R6", "rw change while low", rw_flips, 0);
        chk(width >= MIN_CYC && width <= MAX_CYC, "R4", "width in range", width, MIN_CYC);
        chk(rdy_seen_low && rdy_early == 0, "R7", "ready held during min width",
            rdy_early, 0);
        chk(en_after >= HOLD_CYC, "R8", "enable after strobe", en_after, HOLD_CYC);
    endtask

    task automatic t_data_read();
        bus_cycle(P_DATA, 1'b0, 0, 1'b1);
        chk(ds_lo > 0 && as_lo == 0, "R3", "data port strobes as/ds", as_lo*100 + ds_lo, 1);
        chk(rw_at_fall == 1'b1, "R6", "rw for read", rw_at_fall, 1);
        chk(age_at_fall >= SETUP_CYC, "R6", "rw setup on read", age_at_fall, SETUP_CYC);
        chk(rdy_early == 0 && rdy_seen_low, "R7", "ready on read", rdy_early, 0);
    endtask

    task automatic t_short_pulse();
        bus_cycle(P_DATA, 1'b1, 0, 1'b0);
        chk(falls == 1 && width == MIN_CYC, "R4", "short pulse width", width, MIN_CYC);
        chk(en_after >= HOLD_CYC, "R8", "hold after short strobe", en_after, HOLD_CYC);
    endtask

    task automatic t_long_stretch();
        bus_cycle(P_DATA, 1'b0, 40, 1'b1);
        chk(width == MAX_CYC, "R5", "capped width", width, MAX_CYC);
        chk(falls == 1, "R5", "single strobe while bus held", falls, 1);
    endtask

    task automatic t_dma_stream();
        dma_hlda = 1'b1; dma_dack = 1'b1;
        for (int i = 0; i < 4; i++) observe();
        chk(eng_bus_en, "R9", "enable with hold ack and select", eng_bus_en, 1);
        bus_cycle(8'h00, 1'b1, 0, 1'b1);
        chk(ds_lo > 0 && as_lo == 0, "R3", "DMA access data strobe only",
            as_lo*100 + ds_lo, 1);
        bus_cycle(P_ADDR, 1'b0, 2, 1'b1);
        chk(ds_lo > 0 && as_lo == 0, "R3", "DMA at address port still data",
            as_lo*100 + ds_lo, 1);
        dma_dack = 1'b0;
        for (int i = 0; i < 4; i++) observe();
        bus_cycle(8'h10, 1'b0, 6, 1'b0);
        chk(as_lo == 0 && ds_lo == 0, "R9", "foreign access under hold strobes",
            as_lo + ds_lo, 0);
        chk(en_lo == 0, "R9", "enable kept during foreign access", en_lo, 0);
        dma_hlda = 1'b0;
        for (int i = 0; i < 4; i++) observe();
        chk(!eng_bus_en, "R9", "enable drops with hold ack", eng_bus_en, 0);
    endtask

    task automatic t_foreign_port();
        bus_cycle(8'h22, 1'b1, 6, 1'b0);
        chk(as_lo == 0 && ds_lo == 0, "R10", "undecoded port strobes", as_lo + ds_lo, 0);
        chk(!rdy_seen_low, "R10", "ready stays high", rdy_seen_low, 0);
        dma_hlda = 1'b1;
        for (int i = 0; i < 4; i++) observe();
        chk(!eng_bus_en, "R9", "select cleared by foreign access", eng_bus_en, 0);
        dma_hlda = 1'b0;
        for (int i = 0; i < 4; i++) observe();
    endtask

    task automatic t_reset_req();
        int mism = 0;
        eng_rst_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            observe();
            if (eng_as_n != eng_ds_n) mism++;
        end
        chk(!eng_as_n && !eng_ds_n, "R11", "both strobes low", {eng_as_n, eng_ds_n}, 0);
        chk(dma_rdy, "R11", "ready high in engine reset", dma_rdy, 1);
        eng_rst_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            observe();
            if (eng_as_n != eng_ds_n) mism++;
        end
        chk(eng_as_n && eng_ds_n, "R11", "both strobes released", {eng_as_n, eng_ds_n}, 3);
        chk(mism == 0, "R11", "strobes moved apart", mism, 0);
        bus_cycle(P_DATA, 1'b0, 0, 1'b1);
        chk(ds_lo > 0 && as_lo == 0, "R11", "access works after engine reset",
            as_lo*100 + ds_lo, 1);
    endtask

    initial begin
        prev_rw = 1'b1; prev_low = 1'b0; rw_age = 10;
        clear_stats();
        t_reset_state();
        t_addr_write();
        t_data_read();
        t_short_pulse();
        t_long_stretch();
        t_dma_stream();
        t_foreign_port();
        t_reset_req();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule